// File: doc/BRIEF.md
# CPU Clock Source Selector and Divider

This block picks one of four clock sources for the processor core and divides it down to the CPU clock rate. The sources are a main oscillator, a sub oscillator, an on-chip oscillator and a PLL output. Everything runs on a single fast system clock, and each source arrives as a one-cycle tick enable. The block emits the CPU clock as a one-cycle enable pulse on the system clock, and the watchdog clock as a matching pulse.

Software loads a source code, a divide-mode bit and a 2-bit divide field with a write strobe. Hardware can override the divide-mode bit. It does so when stop mode is entered from one of the fast or on-chip-oscillator power modes, and when the main clock is switched off while running in low-speed mode. A new ratio or source is adopted only at a divider terminal count, so no CPU clock period is ever cut short. If the PLL is chosen with a nonzero divide setting, the setting is ignored and a sticky error flag is raised.

Top module: `cpuclk_src_div`

## Requirements
- R1: After reset the stored setting reads back as source code 2 (on-chip oscillator; codes are 0 main, 1 sub, 2 on-chip, 3 PLL), divide-mode bit 0, divide field 2'b10 and error flag 0, and `cpu_en` pulses once per 16 on-chip oscillator ticks.
- R2: With main or on-chip oscillator selected and the divide-mode bit at 0, the divide field selects the ratio: 2'b00 gives /1, 2'b01 gives /2, 2'b10 gives /16 and 2'b11 gives /4, counted in ticks of the selected source.
- R3: With main or on-chip oscillator selected and the divide-mode bit at 1, the ratio is /8 whatever the divide field holds.
- R4: With the PLL selected, `cpu_en` pulses once per PLL tick whatever the divide setting. A write of source 3 with a nonzero mode bit or field sets `cfg_err`, visible the cycle after the write.
- R5: With the sub oscillator selected, `cpu_en` pulses once per sub tick whatever the divide setting, and `cfg_err` is not set.
- R6: `cfg_err` stays set until reset. A write of source 3 with mode 0 and field 2'b00 does not set it.
- R7: A `stop_entry` pulse while `pwr_mode` is 0 (high speed), 1 (middle speed), 3 (on-chip oscillator) or 4 (on-chip oscillator low power) sets the stored divide-mode bit to 1. With `pwr_mode` at 2 (low speed) or any other code the pulse leaves the bit unchanged.
- R8: A `main_off_req` pulse while `pwr_mode` is 2 sets the stored divide-mode bit to 1. In any other power mode it leaves the bit unchanged.
- R9: A new ratio or source takes effect only at the terminal count of the interval in progress. The interval running when a write lands keeps the old length.
- R10: `wdt_en` equals `cpu_en` on every cycle. Each pulse lasts one system cycle and follows the terminal-count tick by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_tick | input | 1 | Main oscillator tick enable |
| sub_tick | input | 1 | Sub oscillator tick enable |
| oco_tick | input | 1 | On-chip oscillator tick enable |
| pll_tick | input | 1 | PLL output tick enable |
| cfg_we | input | 1 | Write strobe for the stored setting |
| cfg_src | input | 2 | Source code to store |
| cfg_div_mode | input | 1 | Divide-mode bit to store |
| cfg_div_field | input | 2 | Divide field to store |
| pwr_mode | input | 3 | Current power mode code |
| stop_entry | input | 1 | Stop mode entry pulse |
| main_off_req | input | 1 | Main clock switch-off pulse |
| cpu_en | output | 1 | CPU clock enable pulse |
| wdt_en | output | 1 | Watchdog clock enable pulse |
| cfg_err | output | 1 | Sticky PLL divide configuration error |
| cur_src | output | 2 | Stored source code |
| cur_div_mode | output | 1 | Stored divide-mode bit |
| cur_div_field | output | 2 | Stored divide field |

## Verification
The hardest case to reach from the ports is a write that lands partway through a long divide interval, because the shortened-period hazard only shows there. The bench waits for a `cpu_en` pulse at /16 and writes /1 on that same cycle. It then checks that the next gap still spans the full sixteen source ticks, and that only the gaps after it shrink. The hardware overrides are swept across every power mode code, and each result is read back through the stored divide-mode bit.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_SUB  = 2'd1,
        SRC_OCO  = 2'd2,
        SRC_PLL  = 2'd3
    } clk_src_e;

    typedef enum logic [2:0] {
        PM_HIGH   = 3'd0,
        PM_MIDDLE = 3'd1,
        PM_LOW    = 3'd2,
        PM_OCO    = 3'd3,
        PM_OCO_LP = 3'd4
    } pwr_mode_e;

    localparam int MAX_DIV    = 16;
    localparam int CNT_W      = $clog2(MAX_DIV);
    localparam int NUM_SRC    = 4;
    localparam logic [1:0] RST_FIELD = 2'b10;

endpackage

// File: rtl/cpuclk_cfg_ctl.sv
module cpuclk_cfg_ctl
    import cpuclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_src,
    input  logic        wr_mode,
    input  logic [1:0]  wr_field,
    input  logic [2:0]  pwr_mode,
    input  logic        stop_entry,
    input  logic        main_off_req,
    output clk_src_e    src_q_o,
    output logic        mode_q_o,
    output logic [1:0]  field_q_o,
    output logic        err_q_o
);

    typedef struct packed {
        clk_src_e   src;
        logic       mode;
        logic [1:0] field;
        logic       err;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic       stop_forces;
    logic       off_forces;

    always_comb begin
        stop_forces = stop_entry &&
                      (pwr_mode == PM_HIGH || pwr_mode == PM_MIDDLE ||
                       pwr_mode == PM_OCO  || pwr_mode == PM_OCO_LP);
        off_forces  = main_off_req && (pwr_mode == PM_LOW);

        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.src   = clk_src_e'(wr_src);
            cfg_d.mode  = wr_mode;
            cfg_d.field = wr_field;
            if (wr_src == SRC_PLL && (wr_mode || wr_field != 2'b00)) begin
                cfg_d.err = 1'b1;
            end
        end
        // hardware override has priority over a simultaneous write
        if (stop_forces || off_forces) begin
            cfg_d.mode = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.src   <= SRC_OCO;
            cfg_q.mode  <= 1'b0;
            cfg_q.field <= RST_FIELD;
            cfg_q.err   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign src_q_o   = cfg_q.src;
    assign mode_q_o  = cfg_q.mode;
    assign field_q_o = cfg_q.field;
    assign err_q_o   = cfg_q.err;

    a_r7_stop_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry && pwr_mode != PM_LOW && pwr_mode <= PM_OCO_LP) |=> mode_q_o);

    a_r8_mainoff_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (main_off_req && pwr_mode == PM_LOW) |=> mode_q_o);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q_o |=> err_q_o);

endmodule

// File: rtl/cpuclk_ratio_dec.sv
module cpuclk_ratio_dec
    import cpuclk_pkg::*;
#(
    parameter int TERM_W = CNT_W
) (
    input  clk_src_e          src,
    input  logic              mode,
    input  logic [1:0]        field,
    output logic [TERM_W-1:0] term
);

    // term is the ratio minus one, the last count of an interval
    always_comb begin
        term = '0;
        if (src == SRC_MAIN || src == SRC_OCO) begin
            if (mode) begin
                term = TERM_W'(7);
            end else begin
                unique case (field)
                    2'b00: term = TERM_W'(0);
                    2'b01: term = TERM_W'(1);
                    2'b10: term = TERM_W'(15);
                    2'b11: term = TERM_W'(3);
                endcase
            end
        end
    end

endmodule

// File: rtl/cpuclk_tick_div.sv
module cpuclk_tick_div
    import cpuclk_pkg::*;
#(
    parameter int            TERM_W   = CNT_W,
    parameter int            SRC_N    = NUM_SRC,
    parameter clk_src_e      RST_SRC  = SRC_OCO,
    parameter logic [TERM_W-1:0] RST_TERM = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  tick_vec,
    input  clk_src_e          req_src,
    input  logic [TERM_W-1:0] req_term,
    output logic              en_o
);

    typedef struct packed {
        logic [TERM_W-1:0] cnt;
        logic [TERM_W-1:0] term;
        clk_src_e          src;
        logic              en;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d    = div_q;
        div_d.en = 1'b0;
        if (tick_vec[div_q.src]) begin
            if (div_q.cnt == div_q.term) begin
                div_d.cnt  = '0;
                div_d.en   = 1'b1;
                div_d.src  = req_src;
                div_d.term = req_term;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.cnt  <= '0;
            div_q.term <= RST_TERM;
            div_q.src  <= RST_SRC;
            div_q.en   <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign en_o = div_q.en;

    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= div_q.term);

    a_r4_pll_undivided: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.src == SRC_PLL || div_q.src == SRC_SUB) |-> div_q.term == '0);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && div_q.term != '0) |=> !en_o);

endmodule

// File: rtl/cpuclk_src_div.sv
module cpuclk_src_div
    import cpuclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic       oco_tick,
    input  logic       pll_tick,
    input  logic       cfg_we,
    input  logic [1:0] cfg_src,
    input  logic       cfg_div_mode,
    input  logic [1:0] cfg_div_field,
    input  logic [2:0] pwr_mode,
    input  logic       stop_entry,
    input  logic       main_off_req,
    output logic       cpu_en,
    output logic       wdt_en,
    output logic       cfg_err,
    output logic [1:0] cur_src,
    output logic       cur_div_mode,
    output logic [1:0] cur_div_field
);

    clk_src_e           st_src;
    logic               st_mode;
    logic [1:0]         st_field;
    logic [CNT_W-1:0]   req_term;
    logic [NUM_SRC-1:0] ticks;
    logic               en;

    always_comb begin
        ticks           = '0;
        ticks[SRC_MAIN] = main_tick;
        ticks[SRC_SUB]  = sub_tick;
        ticks[SRC_OCO]  = oco_tick;
        ticks[SRC_PLL]  = pll_tick;
    end

    cpuclk_cfg_ctl u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_we),
        .wr_src       (cfg_src),
        .wr_mode      (cfg_div_mode),
        .wr_field     (cfg_div_field),
        .pwr_mode     (pwr_mode),
        .stop_entry   (stop_entry),
        .main_off_req (main_off_req),
        .src_q_o      (st_src),
        .mode_q_o     (st_mode),
        .field_q_o    (st_field),
        .err_q_o      (cfg_err)
    );

    cpuclk_ratio_dec #(.TERM_W(CNT_W)) u_dec (
        .src   (st_src),
        .mode  (st_mode),
        .field (st_field),
        .term  (req_term)
    );

    cpuclk_tick_div #(
        .TERM_W   (CNT_W),
        .SRC_N    (NUM_SRC),
        .RST_SRC  (SRC_OCO),
        .RST_TERM (CNT_W'(MAX_DIV - 1))
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_vec (ticks),
        .req_src  (st_src),
        .req_term (req_term),
        .en_o     (en)
    );

    assign cpu_en        = en;
    assign wdt_en        = en;
    assign cur_src       = st_src;
    assign cur_div_mode  = st_mode;
    assign cur_div_field = st_field;

    a_r3_mode_gives_div8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mode && (st_src == SRC_MAIN || st_src == SRC_OCO)) |-> req_term == CNT_W'(7));

    a_r4_pll_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_src == SRC_PLL && cfg_div_field != 2'b00) |=> cfg_err);

endmodule

// File: tb/cpuclk_src_div_test.sv
module cpuclk_src_div_test;

    localparam int CLK_PERIOD = 10;
    localparam int P_MAIN = 2;
    localparam int P_SUB  = 5;
    localparam int P_OCO  = 3;
    localparam int P_PLL  = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic cfg_div_mode = 1'b0;
    logic [1:0] cfg_div_field = 2'd0;
    logic [2:0] pwr_mode = 3'd0;
    logic stop_entry = 1'b0;
    logic main_off_req = 1'b0;
    logic cpu_en, wdt_en, cfg_err, cur_div_mode;
    logic [1:0] cur_src, cur_div_field;

    int mc = 0, sc = 0, oc = 0, pc = 0;
    int tests = 0, fails = 0, wdt_mismatch = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        mc <= (mc == P_MAIN-1) ? 0 : mc + 1;
        sc <= (sc == P_SUB-1)  ? 0 : sc + 1;
        oc <= (oc == P_OCO-1)  ? 0 : oc + 1;
        pc <= (pc == P_PLL-1)  ? 0 : pc + 1;
        if (wdt_en !== cpu_en) wdt_mismatch <= wdt_mismatch + 1;
    end

    cpuclk_src_div uut (
        .clk(clk), .rst_n(rst_n),
        .main_tick(mc == 0), .sub_tick(sc == 0),
        .oco_tick(oc == 0), .pll_tick(pc == 0),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_div_mode(cfg_div_mode),
        .cfg_div_field(cfg_div_field), .pwr_mode(pwr_mode),
        .stop_entry(stop_entry), .main_off_req(main_off_req),
        .cpu_en(cpu_en), .wdt_en(wdt_en), .cfg_err(cfg_err),
        .cur_src(cur_src), .cur_div_mode(cur_div_mode), .cur_div_field(cur_div_field)
    );

    function automatic int period_of(input int s);
        case (s)
            0: return P_MAIN;
            1: return P_SUB;
            2: return P_OCO;
            default: return P_PLL;
        endcase
    endfunction

    function automatic int ratio_of(input int s, input int m, input int f);
        if (s == 1 || s == 3) return 1;
        if (m != 0) return 8;
        case (f)
            0: return 1;
            1: return 2;
            2: return 16;
            default: return 4;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int s, input int m, input int f);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = 2'(s); cfg_div_mode = 1'(m); cfg_div_field = 2'(f);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (cpu_en !== 1'b1);
    endtask

    task automatic measure(output int gap);
        wait_pulse(); wait_pulse(); wait_pulse();
        gap = 0;
        do begin @(negedge clk); gap++; end while (cpu_en !== 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 src", int'(cur_src), 2);
        check("R1 mode", int'(cur_div_mode), 0);
        check("R1 field", int'(cur_div_field), 2);
        check("R1 err", int'(cfg_err), 0);
        measure(g);
        check("R1 gap", g, 16 * P_OCO);

        // R6 clean PLL write leaves error clear
        write_cfg(3, 0, 0);
        @(negedge clk);
        check("R6 no err on clean pll", int'(cfg_err), 0);

        // R5 sub undivided, no error
        write_cfg(1, 1, 3);
        @(negedge clk);
        check("R5 no err", int'(cfg_err), 0);
        measure(g);
        check("R5 gap", g, P_SUB);

        // R2 R3 sweep on main and on-chip
        for (int s = 0; s <= 2; s += 2) begin
            for (int m = 0; m < 2; m++) begin
                for (int f = 0; f < 4; f++) begin
                    write_cfg(s, m, f);
                    measure(g);
                    check(m ? "R3 div8" : "R2 field ratio", g, ratio_of(s, m, f) * period_of(s));
                end
            end
        end

        // R4 PLL ignores setting, raises error
        write_cfg(3, 1, 2);
        check("R4 err set", int'(cfg_err), 1);
        measure(g);
        check("R4 pll gap", g, P_PLL);

        // R6 sticky
        write_cfg(0, 0, 1);
        repeat (3) @(negedge clk);
        check("R6 err sticky", int'(cfg_err), 1);

        // R7 stop override per power mode
        for (int pm = 0; pm < 6; pm++) begin
            write_cfg(0, 0, 0);
            pwr_mode = 3'(pm);
            stop_entry = 1'b1;
            @(negedge clk);
            stop_entry = 1'b0;
            @(negedge clk);
            check("R7 stop override", int'(cur_div_mode),
                  (pm == 0 || pm == 1 || pm == 3 || pm == 4) ? 1 : 0);
        end
        pwr_mode = 3'd0;
        write_cfg(0, 0, 0);
        stop_entry = 1'b1;
        @(negedge clk);
        stop_entry = 1'b0;
        measure(g);
        check("R7 gap after override", g, 8 * P_MAIN);

        // R8 main-off override only in low speed
        for (int pm = 0; pm < 5; pm++) begin
            write_cfg(0, 0, 1);
            pwr_mode = 3'(pm);
            main_off_req = 1'b1;
            @(negedge clk);
            main_off_req = 1'b0;
            @(negedge clk);
            check("R8 main off override", int'(cur_div_mode), (pm == 2) ? 1 : 0);
        end
        pwr_mode = 3'd0;

        // R9 write lands at a pulse: interval in progress keeps old length
        write_cfg(0, 0, 2);
        wait_pulse(); wait_pulse();
        cfg_we = 1'b1; cfg_src = 2'd0; cfg_div_mode = 1'b0; cfg_div_field = 2'd0;
        g = 0;
        do begin
            @(negedge clk); g++;
            cfg_we = 1'b0;
        end while (cpu_en !== 1'b1);
        check("R9 old interval kept", g, 16 * P_MAIN);
        g = 0;
        do begin @(negedge clk); g++; end while (cpu_en !== 1'b1);
        check("R9 new ratio after tc", g, P_MAIN);

        // R10 watchdog enable tracks cpu enable
        check("R10 wdt mismatches", wdt_mismatch, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule